// File: doc/BRIEF.md
# Programmable-Frame Start-Stop Serial Transceiver

This block is a full-duplex start-stop serial port. A parallel byte handed over on the transmit side goes out on a single line. Serial frames arriving on a second line come back as parallel bytes, each with its own error flags. Three settings can be changed at runtime and are shared by both directions: the word length (7 or 8 bits), the parity mode (none, even or odd) and the stop length on transmit (one, one and a half, or two bit times).

All timing comes from a one-cycle sample enable that runs at sixteen times the bit rate. This enable comes from one of two sources, chosen by a select input. The first is an internal 16-bit reload divider of the system clock, whose divisor is a runtime input; it covers rates from 110 to 9600 bit/s at common clock rates. The second is an external clock pin. That pin is resynchronised, and each rising edge gives one enable.

Software (or a neighbouring block) loads a byte with a valid/ready handshake. It collects received bytes from a one-cycle valid pulse. A 1.5-bit stop time is made exactly, because it lasts 24 sample enables.

Top module: `async_serial_port`

## Requirements
- R1: The transmit line idles high, and `txReady` is high only while the transmitter is idle. A byte is taken when `txValid` and `txReady` are both high at a clock edge. The line goes low for the start bit from that edge. The data bits then follow, least significant bit first, each lasting 16 sample enables.
- R2: When `cfgWord8` is 1, frames carry 8 data bits; when it is 0, they carry 7. In 7-bit mode, `txData[7]` is not sent and `rxData[7]` reads 0.
- R3: `cfgParity` 2'b01 selects even parity and 2'b10 selects odd parity; 2'b00 and 2'b11 mean no parity bit. The parity bit follows the last data bit. Under even parity it makes the count of ones in the data plus parity even; under odd parity it makes that count odd.
- R4: After the last data or parity bit, the line is held high for the stop time. The encoding of `cfgStop` is: 2'b00 is 16 sample enables, 2'b01 is 24, and 2'b10 or 2'b11 is 32. `txReady` stays low until the stop time ends.
- R5: With `cfgExtClk` at 0, a sample enable occurs once every `divisor` clock cycles. A divisor of 0 acts as 1.
- R6: With `cfgExtClk` at 1, each rising edge of `extClk` gives exactly one sample enable. This happens after a two-flop synchroniser, so bit time equals 16 `extClk` periods.
- R7: The receiver looks for a low line on a sample enable. It then samples each bit 8 enables into it and moves on every 16 enables. At the sample point of the first stop bit, it pulses `rxValid` for one cycle, with `rxData` and both error flags valid in that cycle.
- R8: If the line is high again at the middle of the start bit, the receiver drops the start and goes back to idle without producing `rxValid`.
- R9: `rxFrameErr` is set with `rxValid` when the first stop sample is low. The data byte is still delivered.
- R10: `rxParityErr` is set when the received parity bit does not match the selected even or odd mode. It is never set when parity is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| cfgWord8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfgParity | input | 2 | 01 even, 10 odd, 00/11 none |
| cfgStop | input | 2 | 00 one, 01 one and a half, 10/11 two stop bits |
| cfgExtClk | input | 1 | 1 selects the external sample clock |
| divisor | input | 16 | Internal divider reload value (clocks per sample enable) |
| extClk | input | 1 | External 16x sample clock |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | Transmit byte offered |
| txReady | output | 1 | Transmitter idle and able to take a byte |
| txLine | output | 1 | Serial output |
| rxLine | input | 1 | Serial input (asynchronous) |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | One-cycle pulse: received byte and flags valid |
| rxParityErr | output | 1 | Parity mismatch on the received byte |
| rxFrameErr | output | 1 | First stop sample was low |

## Verification
The hardest behaviour to reach from the ports is the rejection of a short low pulse on the receive line. Only a malformed waveform reaches it, and a transmitter that is correct never produces one. So the bench switches the receiver from loopback to its own line driver. It then applies a pulse a few sample enables long and follows it with a valid frame. A spurious `rxValid` fails against the empty queue of expected results, and the next byte must still decode cleanly. The bench uses the same driver to build frames with a wrong parity bit and frames with a low stop bit, and it holds that stop bit low only briefly. It also tells the stop lengths and the clock sources apart by measuring the time between the start edges of frames sent back to back.

// File: rtl/asp_pkg.sv
package asp_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } phase_t;

  // strobes from the control FSMs to the datapath
  typedef struct packed {
    logic load;
    logic shiftOut;
    logic putParity;
    logic putStop;
  } txStrobe_t;

  typedef struct packed {
    logic clear;
    logic takeData;
    logic takeParity;
    logic takeStop;
  } rxStrobe_t;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  function automatic logic parityOn(input logic [1:0] mode);
    return (mode == PAR_EVEN) || (mode == PAR_ODD);
  endfunction

  function automatic logic parityOdd(input logic [1:0] mode);
    return mode == PAR_ODD;
  endfunction

endpackage

// File: rtl/asp_baud.sv
module asp_baud #(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             useExt,
  input  logic [DIV_W-1:0] divisor,
  input  logic             extClk,
  output logic             tick
);

  logic [DIV_W-1:0]     divCnt;
  logic [SYNC_STAGES:0] extSync;
  logic                 intHit;
  logic                 extRise;
  logic [DIV_W-1:0]     reloadVal;

  assign intHit    = (divCnt == '0);
  assign extRise   = extSync[SYNC_STAGES-1] & ~extSync[SYNC_STAGES];
  assign reloadVal = (divisor == '0) ? '0 : divisor - DIV_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      extSync <= '0;
      tick    <= 1'b0;
    end else begin
      divCnt  <= intHit ? reloadVal : divCnt - DIV_W'(1);
      extSync <= {extSync[SYNC_STAGES-1:0], extClk};
      tick    <= useExt ? extRise : intHit;
    end
  end

  // R5: with a stable divisor above one, enables never come back to back
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !useExt && $stable(useExt) && $stable(divisor) && divisor > DIV_W'(1))
      |=> !tick);

  // R6: a resynchronised edge cannot give two enables in a row
  p_ext_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && useExt && $stable(useExt)) |=> !tick);

endmodule

// File: rtl/asp_ctrl.sv
module asp_ctrl
  import asp_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       txValid,
  input  logic       cfgWord8,
  input  logic [1:0] cfgParity,
  input  logic [1:0] cfgStop,
  input  logic       rxBit,
  output logic       txReady,
  output txStrobe_t  txStb,
  output rxStrobe_t  rxStb
);

  localparam int TX_W = $clog2(2 * OSR + 1);
  localparam int RX_W = $clog2(OSR);
  localparam logic [TX_W-1:0] TX_END   = TX_W'(OSR - 1);
  localparam logic [RX_W-1:0] RX_MID   = RX_W'(OSR / 2 - 1);
  localparam logic [RX_W-1:0] RX_END   = RX_W'(OSR - 1);

  phase_t          txState, txNext, rxState, rxNext;
  logic [TX_W-1:0] txCnt, txCntNext, stopLast;
  logic [2:0]      txIdx, txIdxNext, rxIdx, rxIdxNext, lastIdx;
  logic [RX_W-1:0] rxCnt, rxCntNext;
  logic            txBitEnd;

  assign lastIdx  = cfgWord8 ? 3'd7 : 3'd6;
  assign txBitEnd = tick && (txCnt == TX_END);

  always_comb begin
    case (cfgStop)
      2'b00:   stopLast = TX_W'(OSR - 1);
      2'b01:   stopLast = TX_W'(OSR + OSR / 2 - 1);
      default: stopLast = TX_W'(2 * OSR - 1);
    endcase
  end

  // transmit sequencing
  always_comb begin
    txNext    = txState;
    txCntNext = txCnt;
    txIdxNext = txIdx;
    txStb     = '0;
    txReady   = (txState == S_IDLE);
    case (txState)
      S_IDLE: if (txValid) begin
        txStb.load = 1'b1;
        txNext     = S_START;
        txCntNext  = '0;
      end
      S_START: if (tick) begin
        if (txBitEnd) begin
          txCntNext      = '0;
          txIdxNext      = '0;
          txStb.shiftOut = 1'b1;
          txNext         = S_DATA;
        end else txCntNext = txCnt + TX_W'(1);
      end
      S_DATA: if (tick) begin
        if (txBitEnd) begin
          txCntNext = '0;
          if (txIdx == lastIdx) begin
            if (parityOn(cfgParity)) begin
              txStb.putParity = 1'b1;
              txNext          = S_PAR;
            end else begin
              txStb.putStop = 1'b1;
              txNext        = S_STOP;
            end
          end else begin
            txIdxNext      = txIdx + 3'd1;
            txStb.shiftOut = 1'b1;
          end
        end else txCntNext = txCnt + TX_W'(1);
      end
      S_PAR: if (tick) begin
        if (txBitEnd) begin
          txCntNext     = '0;
          txStb.putStop = 1'b1;
          txNext        = S_STOP;
        end else txCntNext = txCnt + TX_W'(1);
      end
      S_STOP: if (tick) begin
        if (txCnt == stopLast) begin
          txCntNext = '0;
          txNext    = S_IDLE;
        end else txCntNext = txCnt + TX_W'(1);
      end
      default: txNext = S_IDLE;
    endcase
  end

  // receive sequencing
  always_comb begin
    rxNext    = rxState;
    rxCntNext = rxCnt;
    rxIdxNext = rxIdx;
    rxStb     = '0;
    case (rxState)
      S_IDLE: if (tick && !rxBit) begin
        rxStb.clear = 1'b1;
        rxCntNext   = '0;
        rxNext      = S_START;
      end
      S_START: if (tick) begin
        if (rxCnt == RX_MID && rxBit) begin
          rxCntNext = '0;
          rxNext    = S_IDLE;
        end else if (rxCnt == RX_END) begin
          rxCntNext = '0;
          rxIdxNext = '0;
          rxNext    = S_DATA;
        end else rxCntNext = rxCnt + RX_W'(1);
      end
      S_DATA: if (tick) begin
        if (rxCnt == RX_MID) rxStb.takeData = 1'b1;
        if (rxCnt == RX_END) begin
          rxCntNext = '0;
          if (rxIdx == lastIdx) rxNext = parityOn(cfgParity) ? S_PAR : S_STOP;
          else rxIdxNext = rxIdx + 3'd1;
        end else rxCntNext = rxCnt + RX_W'(1);
      end
      S_PAR: if (tick) begin
        if (rxCnt == RX_MID) rxStb.takeParity = 1'b1;
        if (rxCnt == RX_END) begin
          rxCntNext = '0;
          rxNext    = S_STOP;
        end else rxCntNext = rxCnt + RX_W'(1);
      end
      S_STOP: if (tick) begin
        if (rxCnt == RX_MID) begin
          rxStb.takeStop = 1'b1;
          rxCntNext      = '0;
          rxNext         = S_IDLE;
        end else rxCntNext = rxCnt + RX_W'(1);
      end
      default: rxNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= S_IDLE;
      txCnt   <= '0;
      txIdx   <= '0;
      rxState <= S_IDLE;
      rxCnt   <= '0;
      rxIdx   <= '0;
    end else begin
      txState <= txNext;
      txCnt   <= txCntNext;
      txIdx   <= txIdxNext;
      rxState <= rxNext;
      rxCnt   <= rxCntNext;
      rxIdx   <= rxIdxNext;
    end
  end

  // R2: the data-bit index stays within the selected word length
  p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txState == S_DATA && $stable(cfgWord8)) |-> (txIdx <= lastIdx));

endmodule

// File: rtl/asp_datapath.sv
module asp_datapath
  import asp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  txStrobe_t  txStb,
  input  rxStrobe_t  rxStb,
  input  logic       cfgWord8,
  input  logic [1:0] cfgParity,
  input  logic [7:0] txData,
  input  logic       rxLine,
  output logic       txLine,
  output logic       rxBit,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       rxParityErr,
  output logic       rxFrameErr
);

  logic [7:0]             txShift, rxShift;
  logic                   txPar, rxPar, rxPerr;
  logic [SYNC_STAGES-1:0] rxSync;

  assign rxBit = rxSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      txPar   <= 1'b0;
      txLine  <= 1'b1;
    end else if (txStb.load) begin
      txShift <= txData;
      txPar   <= 1'b0;
      txLine  <= 1'b0;
    end else if (txStb.shiftOut) begin
      txLine  <= txShift[0];
      txPar   <= txPar ^ txShift[0];
      txShift <= {1'b0, txShift[7:1]};
    end else if (txStb.putParity) begin
      txLine <= txPar ^ parityOdd(cfgParity);
    end else if (txStb.putStop) begin
      txLine <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync      <= '1;
      rxShift     <= '0;
      rxPar       <= 1'b0;
      rxPerr      <= 1'b0;
      rxData      <= '0;
      rxValid     <= 1'b0;
      rxParityErr <= 1'b0;
      rxFrameErr  <= 1'b0;
    end else begin
      rxSync  <= {rxSync[SYNC_STAGES-2:0], rxLine};
      rxValid <= 1'b0;
      if (rxStb.clear) begin
        rxShift <= '0;
        rxPar   <= 1'b0;
        rxPerr  <= 1'b0;
      end
      if (rxStb.takeData) begin
        rxShift <= {rxBit, rxShift[7:1]};
        rxPar   <= rxPar ^ rxBit;
      end
      if (rxStb.takeParity) rxPerr <= rxBit ^ rxPar ^ parityOdd(cfgParity);
      if (rxStb.takeStop) begin
        rxValid     <= 1'b1;
        rxData      <= cfgWord8 ? rxShift : {1'b0, rxShift[7:1]};
        rxParityErr <= parityOn(cfgParity) & rxPerr;
        rxFrameErr  <= ~rxBit;
      end
    end
  end

  // R1: the sequencer never asks for two line actions at once
  p_tx_strobe_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(txStb));

  // R7: receive actions are mutually exclusive
  p_rx_strobe_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rxStb));

endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
  import asp_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWord8,
  input  logic [1:0]       cfgParity,
  input  logic [1:0]       cfgStop,
  input  logic             cfgExtClk,
  input  logic [DIV_W-1:0] divisor,
  input  logic             extClk,
  input  logic [7:0]       txData,
  input  logic             txValid,
  output logic             txReady,
  output logic             txLine,
  input  logic             rxLine,
  output logic [7:0]       rxData,
  output logic             rxValid,
  output logic             rxParityErr,
  output logic             rxFrameErr
);

  logic      tick;
  logic      rxBit;
  txStrobe_t txStb;
  rxStrobe_t rxStb;

  asp_baud #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_baud (
    .clk(clk), .rstN(rstN), .useExt(cfgExtClk), .divisor(divisor),
    .extClk(extClk), .tick(tick)
  );

  asp_ctrl #(.OSR(OSR)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .txValid(txValid),
    .cfgWord8(cfgWord8), .cfgParity(cfgParity), .cfgStop(cfgStop),
    .rxBit(rxBit), .txReady(txReady), .txStb(txStb), .rxStb(rxStb)
  );

  asp_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .txStb(txStb), .rxStb(rxStb),
    .cfgWord8(cfgWord8), .cfgParity(cfgParity), .txData(txData),
    .rxLine(rxLine), .txLine(txLine), .rxBit(rxBit), .rxData(rxData),
    .rxValid(rxValid), .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr)
  );

  // R1: an accepted byte starts its frame with a low start bit
  p_accept_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txLine);

  // R1: the line is high whenever the transmitter offers readiness
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txLine);

  // R7: receive valid is a single-cycle pulse
  p_rx_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R10: no parity error is reported with parity switched off
  p_no_perr_none_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !parityOn(cfgParity) && $stable(cfgParity)) |-> !rxParityErr);

endmodule

// File: tb/sim_async_serial_port.sv
module sim_async_serial_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWord8 = 1'b1;
  logic [1:0]  cfgParity = 2'b00;
  logic [1:0]  cfgStop = 2'b00;
  logic        cfgExtClk = 1'b0;
  logic [15:0] divisor = 16'd4;
  logic        extClk = 1'b0;
  logic [7:0]  txData = 8'h00;
  logic        txValid = 1'b0;
  logic        txReady, txLine;
  logic        benchRx = 1'b1;
  logic        loopOn = 1'b1;
  logic        rxLine;
  logic [7:0]  rxData;
  logic        rxValid, rxParityErr, rxFrameErr;

  int nChecks = 0;
  int nFail = 0;
  int T = 4;
  int cyc = 0;
  bit extRun = 1'b0;
  bit finished = 1'b0;

  logic [11:0] txExpQ[$];
  int          txLenQ[$];
  logic [9:0]  rxExpQ[$];
  string       rxReqQ[$];

  bit          monActive = 1'b0;
  int          monCnt = 0;
  int          monBit = 0;
  logic [11:0] monBits = '0;
  int          monLen = 0;
  logic        prevLine = 1'b1;
  int          lastFall = 0;
  int          lastGap = 0;

  assign rxLine = loopOn ? txLine : benchRx;

  async_serial_port u0 (
    .clk(clk), .rstN(rstN), .cfgWord8(cfgWord8), .cfgParity(cfgParity),
    .cfgStop(cfgStop), .cfgExtClk(cfgExtClk), .divisor(divisor),
    .extClk(extClk), .txData(txData), .txValid(txValid), .txReady(txReady),
    .txLine(txLine), .rxLine(rxLine), .rxData(rxData), .rxValid(rxValid),
    .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  function automatic int parBits(input logic [1:0] pm);
    return (pm == 2'b01 || pm == 2'b10) ? 1 : 0;
  endfunction

  function automatic logic [11:0] mkBits(input logic [7:0] d, input logic w8,
                                         input logic [1:0] pm, input logic flip,
                                         input logic stopv);
    logic [11:0] b;
    int n;
    int k;
    logic x;
    b = '1;
    n = w8 ? 8 : 7;
    b[0] = 1'b0;
    x = 1'b0;
    for (int i = 0; i < n; i++) begin
      b[1+i] = d[i];
      x ^= d[i];
    end
    k = 1 + n;
    if (parBits(pm) == 1) begin
      b[k] = x ^ (pm == 2'b10) ^ flip;
      k++;
    end
    b[k] = stopv;
    return b;
  endfunction

  function automatic int mkLen(input logic w8, input logic [1:0] pm);
    return 2 + (w8 ? 8 : 7) + parBits(pm);
  endfunction

  // cycle counter and external sample clock
  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (extRun) begin
        ph++;
        if (ph == 3) begin
          ph = 0;
          extClk = ~extClk;
        end
      end
    end
  end

  // behavioural line monitor for the transmit side
  initial forever begin
    @(negedge clk);
    if (rstN) begin
      if (!monActive) begin
        if (prevLine && !txLine) begin
          lastGap  = cyc - lastFall;
          lastFall = cyc;
          if (txExpQ.size() == 0) check(1'b0, "R1", "unexpected start bit", 0, 1);
          else begin
            monBits   = txExpQ.pop_front();
            monLen    = txLenQ.pop_front();
            monActive = 1'b1;
            monCnt    = 0;
            monBit    = 0;
          end
        end
      end else begin
        monCnt++;
        if (monCnt == 8 * T + 16 * T * monBit) begin
          if (monBit == monLen - 1) begin
            check(txLine == monBits[monBit], "R4", "stop bit level", int'(txLine), int'(monBits[monBit]));
            check(!txReady, "R4", "txReady during stop", int'(txReady), 0);
            monActive = 1'b0;
          end else if (monBit == monLen - 2 && parBits(cfgParity) == 1) begin
            check(txLine == monBits[monBit], "R3", "parity bit", int'(txLine), int'(monBits[monBit]));
          end else begin
            check(txLine == monBits[monBit], "R1", $sformatf("tx bit %0d", monBit), int'(txLine), int'(monBits[monBit]));
          end
          monBit++;
        end
      end
    end
    prevLine = txLine;
  end

  // receive result checker
  initial forever begin
    @(negedge clk);
    if (rstN && rxValid) begin
      if (rxExpQ.size() == 0) begin
        check(1'b0, "R8", "unexpected rxValid", int'(rxData), 0);
      end else begin
        logic [9:0] e;
        string r;
        e = rxExpQ.pop_front();
        r = rxReqQ.pop_front();
        check({rxData, rxParityErr, rxFrameErr} == e, r, "rx byte/flags",
              int'({rxData, rxParityErr, rxFrameErr}), int'(e));
      end
    end
  end

  task automatic txSend(input logic [7:0] d, input string req);
    txExpQ.push_back(mkBits(d, cfgWord8, cfgParity, 1'b0, 1'b1));
    txLenQ.push_back(mkLen(cfgWord8, cfgParity));
    rxExpQ.push_back({(cfgWord8 ? d : {1'b0, d[6:0]}), 1'b0, 1'b0});
    rxReqQ.push_back(req);
    @(negedge clk);
    txValid = 1'b1;
    txData  = d;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (txExpQ.size() != 0 || monActive || rxExpQ.size() != 0) @(negedge clk);
    repeat (32 * T) @(negedge clk);
  endtask

  task automatic checkGap(input string req, input int nTicks);
    check(lastGap >= (nTicks - 1) * T && lastGap <= nTicks * T + 3, req,
          "start-to-start spacing", lastGap, nTicks * T);
  endtask

  task automatic rxDrive(input logic [11:0] bits, input int len, input bit stopOk);
    for (int i = 0; i < len - 1; i++) begin
      benchRx = bits[i];
      repeat (16 * T) @(negedge clk);
    end
    if (stopOk) begin
      benchRx = 1'b1;
    end else begin
      benchRx = 1'b0;
      repeat (12 * T) @(negedge clk);
      benchRx = 1'b1;
    end
    repeat (48 * T) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", cyc, 0);
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txLine == 1'b1, "R1", "reset line level", int'(txLine), 1);
    check(txReady == 1'b1, "R1", "reset txReady", int'(txReady), 1);
    check(rxValid == 1'b0, "R7", "reset rxValid", int'(rxValid), 0);

    // 8N1 loopback, several patterns
    txSend(8'h55, "R7"); txSend(8'hA3, "R7"); txSend(8'h00, "R1"); txSend(8'hFF, "R1");
    waitIdle();

    // parity and word length
    cfgParity = 2'b01; txSend(8'h3C, "R3"); txSend(8'h81, "R3"); waitIdle();
    cfgParity = 2'b10; cfgStop = 2'b10; txSend(8'h7E, "R3"); waitIdle();
    cfgWord8 = 1'b0; cfgParity = 2'b01; cfgStop = 2'b00; txSend(8'hC5, "R2"); waitIdle();
    cfgParity = 2'b00; cfgStop = 2'b01; txSend(8'hB3, "R2"); waitIdle();

    // stop lengths: spacing of back-to-back frames
    cfgWord8 = 1'b1;
    cfgStop = 2'b00; txSend(8'h12, "R4"); txSend(8'h34, "R4"); waitIdle(); checkGap("R4", 160);
    cfgStop = 2'b01; txSend(8'h56, "R4"); txSend(8'h78, "R4"); waitIdle(); checkGap("R4", 168);
    cfgStop = 2'b11; txSend(8'h9A, "R4"); txSend(8'hBC, "R4"); waitIdle(); checkGap("R4", 176);

    // internal divider at another divisor
    cfgStop = 2'b00; divisor = 16'd2; T = 2;
    txSend(8'h69, "R5"); txSend(8'hE1, "R5"); waitIdle(); checkGap("R5", 160);

    // external sample clock, period 6 cycles
    extRun = 1'b1; repeat (20) @(negedge clk);
    cfgExtClk = 1'b1; T = 6;
    txSend(8'h96, "R6"); txSend(8'h2D, "R6"); waitIdle(); checkGap("R6", 160);
    cfgExtClk = 1'b0; extRun = 1'b0; divisor = 16'd4; T = 4;
    repeat (40) @(negedge clk);

    // receiver driven directly by the bench
    loopOn = 1'b0;
    repeat (20) @(negedge clk);
    cfgParity = 2'b01;
    rxExpQ.push_back({8'h01, 1'b1, 1'b0}); rxReqQ.push_back("R10");
    rxDrive(mkBits(8'h01, 1'b1, 2'b01, 1'b1, 1'b1), 11, 1'b1);
    cfgParity = 2'b10;
    rxExpQ.push_back({8'h07, 1'b0, 1'b0}); rxReqQ.push_back("R10");
    rxDrive(mkBits(8'h07, 1'b1, 2'b10, 1'b0, 1'b1), 11, 1'b1);
    rxExpQ.push_back({8'h07, 1'b1, 1'b0}); rxReqQ.push_back("R10");
    rxDrive(mkBits(8'h07, 1'b1, 2'b10, 1'b1, 1'b1), 11, 1'b1);
    cfgParity = 2'b00;
    rxExpQ.push_back({8'h07, 1'b0, 1'b0}); rxReqQ.push_back("R10");
    rxDrive(mkBits(8'h07, 1'b1, 2'b00, 1'b0, 1'b1), 10, 1'b1);
    rxExpQ.push_back({8'hC3, 1'b0, 1'b1}); rxReqQ.push_back("R9");
    rxDrive(mkBits(8'hC3, 1'b1, 2'b00, 1'b0, 1'b0), 10, 1'b0);

    // short low pulse: must be dropped, then a clean frame
    benchRx = 1'b0;
    repeat (3 * T) @(negedge clk);
    benchRx = 1'b1;
    repeat (48 * T) @(negedge clk);
    check(rxExpQ.size() == 0, "R8", "results pending after glitch", rxExpQ.size(), 0);
    rxExpQ.push_back({8'h5A, 1'b0, 1'b0}); rxReqQ.push_back("R8");
    rxDrive(mkBits(8'h5A, 1'b1, 2'b00, 1'b0, 1'b1), 10, 1'b1);
    waitIdle();
    check(rxExpQ.size() == 0, "R7", "all expected bytes received", rxExpQ.size(), 0);
    finishRun();
  end

endmodule